// File: doc/BRIEF.md
# ARINC 429 Transmit Serializer

This block pulls 32-bit words from a show-ahead transmit queue and sends them as ARINC 429 return-to-zero bit pairs on two digital lines: a "high" line and a "low" line. Each bit time starts with a data half and ends with a null half. A fixed gap of four bit times separates consecutive words. All bit timing counts pulses of a 1 MHz enable, so the block runs from any faster system clock. A configuration input picks high speed or low speed.

The 32nd bit can be sent as loaded, or replaced by an odd or even parity bit computed over the first 31 bits. Transmission starts on its own whenever a word is queued (automatic mode), or waits for a start strobe (strobe mode). In strobe mode, one strobe drains everything queued, including words added while the queue is still being sent. A driver-disable input silences the line outputs. A separate pair of loopback outputs carries the same stream for self-test and ignores the disable. A drained output reports that nothing is queued and nothing is in flight.

Top module: `a429_tx_serializer`

## Requirements
- R1: While `rst` is high, all four line outputs are low and `fifo_pop` is low. With an empty queue, `drained` is high one clock after reset is released.
- R2: Bit 1 of the ARINC word is `fifo_data[0]` and is sent first. A one drives `tx_hi`=1 and `tx_lo`=0, a zero drives `tx_hi`=0 and `tx_lo`=1, and null drives both low. The two lines are never high together.
- R3: At high speed (`cfg_low_speed`=0), each bit has 5 enable pulses of data followed by 5 of null.
- R4: At low speed (`cfg_low_speed`=1), each bit has 40 enable pulses of data followed by 40 of null.
- R5: After the null half of bit 32, the lines stay null for a further 4 bit times (40 pulses at high speed, 320 at low speed) before the next word's first data half.
- R6: With `cfg_par_en`=0, all 32 bits are sent exactly as loaded.
- R7: With `cfg_par_en`=1, bit 32 is replaced so that the whole word has an odd number of ones (`cfg_par_even`=0) or an even number (`cfg_par_even`=1).
- R8: In automatic mode (`cfg_auto_start`=1), an idle block pops a queued word on the next clock edge. That word's first data half appears on the lines one clock after the pop.
- R9: In strobe mode (`cfg_auto_start`=0), no word is popped and the lines stay null until `start_pulse` is seen.
- R10: After a strobe, words keep being sent back to back until the queue is empty when a word's gap ends. This includes words queued during transmission. Words queued after that wait for the next strobe.
- R11: `drained` is high only when the block is idle and the queue is empty. It is low while a word or its gap is in progress.
- R12: `cfg_drv_off`=1 forces `tx_hi` and `tx_lo` null from the next clock. `loop_hi` and `loop_lo` keep carrying the stream.
- R13: A synchronous reset during a word returns the lines to null at the next edge. The aborted word is dropped and not resumed.
- R14: Bit timing advances only on `tick_1m`. With no enable pulses, the line outputs hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1m | input | 1 | 1 MHz timing enable, one clock wide |
| cfg_low_speed | input | 1 | 0: 10-pulse bits, 1: 80-pulse bits |
| cfg_par_en | input | 1 | Replace bit 32 with parity |
| cfg_par_even | input | 1 | Parity sense: 0 odd, 1 even |
| cfg_auto_start | input | 1 | 1: send whenever queued, 0: wait for strobe |
| cfg_drv_off | input | 1 | Force line outputs to null |
| start_pulse | input | 1 | Strobe that starts draining the queue |
| fifo_empty | input | 1 | Queue has no word |
| fifo_data | input | WORD_BITS | Head word of the show-ahead queue |
| fifo_pop | output | 1 | Consume the head word |
| tx_hi | output | 1 | Line output, high for a one |
| tx_lo | output | 1 | Line output, high for a zero |
| loop_hi | output | 1 | Self-test copy of the high line, not silenced |
| loop_lo | output | 1 | Self-test copy of the low line, not silenced |
| drained | output | 1 | Idle with an empty queue |

## Verification
The bench decodes every word off the lines. It measures the width of each data and null half and the null run between words, so an off-by-one phase counter or a gap that omits or repeats the null half of bit 32 shows up as a wrong cycle count. Walking-one and constant words with parity on, in both senses, catch a parity bit taken over the wrong span or with the wrong polarity. A bit order mistake scrambles the decoded value. The strobe test queues a word in the middle of a transmission, then another after the drain. A design that stops after one word, or that keeps running after the drain, either loses the middle word or sends the late one unasked. Holding the enable low, disabling the driver and resetting mid-word each target a design that advances without a pulse, leaks data onto silenced lines, or resumes an aborted word.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_NULL = 2'd2,
    ST_GAP  = 2'd3
  } tx_state_e;
endpackage

// File: rtl/a429_tx_phase_timer.sv
// Counts enable pulses inside one phase; flags the last pulse of the phase.
module a429_tx_phase_timer #(
  parameter int HS_HALF  = 5,
  parameter int LS_HALF  = 40,
  parameter int GAP_BITS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic low_speed,
  input  logic gap_sel,
  input  logic restart,
  output logic phase_end
);
  localparam int HS_GAP = HS_HALF * 2 * GAP_BITS;
  localparam int LS_GAP = LS_HALF * 2 * GAP_BITS;
  localparam int MAXV   = (LS_GAP > HS_GAP) ? LS_GAP : HS_GAP;
  localparam int CW     = $clog2(MAXV + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  always_comb begin
    if (gap_sel) last = low_speed ? CW'(LS_GAP - 1) : CW'(HS_GAP - 1);
    else         last = low_speed ? CW'(LS_HALF - 1) : CW'(HS_HALF - 1);
  end

  assign phase_end = tick && (cnt == last);

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (tick)      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/a429_tx_word_fmt.sv
// Optionally replaces the last bit of the word by a parity bit.
module a429_tx_word_fmt #(
  parameter int W = 32
) (
  input  logic [W-1:0] raw,
  input  logic         par_en,
  input  logic         par_even,
  output logic [W-1:0] fmt
);
  logic low_ones_odd;
  assign low_ones_odd = ^raw[W-2:0];

  always_comb begin
    if (par_en) fmt = {(par_even ? low_ones_odd : ~low_ones_odd), raw[W-2:0]};
    else        fmt = raw;
  end
endmodule

// File: rtl/a429_tx_seq.sv
// Word sequencer: launch, data/null phases per bit, inter-word gap.
module a429_tx_seq
  import a429_tx_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         fifo_empty,
  input  logic         auto_start,
  input  logic         start_pulse,
  input  logic [W-1:0] word_in,
  input  logic         phase_end,
  output logic         fifo_pop,
  output logic         restart,
  output logic         in_gap,
  output tx_state_e    state,
  output logic         cur_bit
);
  localparam int BW = $clog2(W);

  tx_state_e      nxt;
  logic [W-1:0]   sh;
  logic [BW-1:0]  bidx;
  logic           run_q;
  logic           go;
  logic           load;

  assign go = !rst && !fifo_empty && (auto_start || run_q || start_pulse);

  always_comb begin
    nxt  = state;
    load = 1'b0;
    case (state)
      ST_IDLE: if (go) begin nxt = ST_DATA; load = 1'b1; end
      ST_DATA: if (phase_end) nxt = ST_NULL;
      ST_NULL: if (phase_end) nxt = (bidx == BW'(W - 1)) ? ST_GAP : ST_DATA;
      ST_GAP:  if (phase_end) begin
                 if (go) begin nxt = ST_DATA; load = 1'b1; end
                 else nxt = ST_IDLE;
               end
      default: nxt = ST_IDLE;
    endcase
  end

  assign fifo_pop = load;
  assign restart  = (nxt != state);
  assign in_gap   = (state == ST_GAP);
  assign cur_bit  = sh[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      sh    <= '0;
      bidx  <= '0;
      run_q <= 1'b0;
    end else begin
      state <= nxt;
      if (load) begin
        sh   <= word_in;
        bidx <= '0;
      end else if (state == ST_NULL && nxt == ST_DATA) begin
        sh   <= {1'b0, sh[W-1:1]};
        bidx <= bidx + 1'b1;
      end
      if (start_pulse)                           run_q <= 1'b1;
      else if (state == ST_IDLE && fifo_empty)   run_q <= 1'b0;
    end
  end
endmodule

// File: rtl/a429_tx_serializer.sv
module a429_tx_serializer
  import a429_tx_pkg::*;
#(
  parameter int WORD_BITS = 32,
  parameter int HS_HALF   = 5,
  parameter int LS_HALF   = 40,
  parameter int GAP_BITS  = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick_1m,
  input  logic                 cfg_low_speed,
  input  logic                 cfg_par_en,
  input  logic                 cfg_par_even,
  input  logic                 cfg_auto_start,
  input  logic                 cfg_drv_off,
  input  logic                 start_pulse,
  input  logic                 fifo_empty,
  input  logic [WORD_BITS-1:0] fifo_data,
  output logic                 fifo_pop,
  output logic                 tx_hi,
  output logic                 tx_lo,
  output logic                 loop_hi,
  output logic                 loop_lo,
  output logic                 drained
);
  logic [WORD_BITS-1:0] fmt_word;
  logic                 phase_end;
  logic                 restart;
  logic                 in_gap;
  logic                 cur_bit;
  tx_state_e            state;
  logic                 hi_n;
  logic                 lo_n;

  a429_tx_word_fmt #(.W(WORD_BITS)) u_fmt (
    .raw      (fifo_data),
    .par_en   (cfg_par_en),
    .par_even (cfg_par_even),
    .fmt      (fmt_word)
  );

  a429_tx_phase_timer #(
    .HS_HALF  (HS_HALF),
    .LS_HALF  (LS_HALF),
    .GAP_BITS (GAP_BITS)
  ) u_timer (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick_1m),
    .low_speed (cfg_low_speed),
    .gap_sel   (in_gap),
    .restart   (restart),
    .phase_end (phase_end)
  );

  a429_tx_seq #(.W(WORD_BITS)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .fifo_empty  (fifo_empty),
    .auto_start  (cfg_auto_start),
    .start_pulse (start_pulse),
    .word_in     (fmt_word),
    .phase_end   (phase_end),
    .fifo_pop    (fifo_pop),
    .restart     (restart),
    .in_gap      (in_gap),
    .state       (state),
    .cur_bit     (cur_bit)
  );

  assign hi_n = (state == ST_DATA) &&  cur_bit;
  assign lo_n = (state == ST_DATA) && !cur_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_hi   <= 1'b0;
      tx_lo   <= 1'b0;
      loop_hi <= 1'b0;
      loop_lo <= 1'b0;
      drained <= 1'b0;
    end else begin
      loop_hi <= hi_n;
      loop_lo <= lo_n;
      tx_hi   <= hi_n && !cfg_drv_off;
      tx_lo   <= lo_n && !cfg_drv_off;
      drained <= (state == ST_IDLE) && fifo_empty;
    end
  end
endmodule

// File: rtl/a429_tx_serializer_chk.sv
module a429_tx_serializer_chk (
  input logic clk,
  input logic rst,
  input logic tick_1m,
  input logic cfg_drv_off,
  input logic fifo_empty,
  input logic fifo_pop,
  input logic tx_hi,
  input logic tx_lo,
  input logic loop_hi,
  input logic loop_lo
);
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  // R1 R13
  always @(negedge clk) begin
    if (rst_q) begin
      reset_null_chk: assert (!tx_hi && !tx_lo && !loop_hi && !loop_lo);
    end
  end

  // R2
  line_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(tx_hi && tx_lo) && !(loop_hi && loop_lo));

  // R8
  pop_valid_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |-> !fifo_empty);

  // R8
  pop_to_data_chk: assert property (@(posedge clk) disable iff (rst)
    $past(fifo_pop) && $past(!rst) && !cfg_drv_off |=> (tx_hi || tx_lo));

  // R12
  drv_off_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_drv_off |=> (!tx_hi && !tx_lo));

  // R14
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!tick_1m && !fifo_pop && !rst) && $stable(cfg_drv_off)
      |=> $stable(tx_hi) && $stable(tx_lo));
endmodule

bind a429_tx_serializer a429_tx_serializer_chk u_chk (.*);

// File: tb/tb_a429_tx_serializer.sv
module tb_a429_tx_serializer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_1m = 1'b1;
  logic        cfg_low_speed = 1'b0;
  logic        cfg_par_en = 1'b0;
  logic        cfg_par_even = 1'b0;
  logic        cfg_auto_start = 1'b1;
  logic        cfg_drv_off = 1'b0;
  logic        start_pulse = 1'b0;
  logic        fifo_empty;
  logic [31:0] fifo_data;
  logic        fifo_pop;
  logic        tx_hi, tx_lo, loop_hi, loop_lo, drained;

  int total = 0;
  int bad = 0;
  int wp = 0;
  int rp = 0;
  logic [31:0] fm [0:63];
  int tdiv = 1;
  int tcnt = 0;
  bit thold = 1'b0;
  bit txnull_mon = 1'b0;
  int txnull_err = 0;

  always #10 clk = ~clk;

  assign fifo_empty = (wp == rp);
  assign fifo_data  = fm[rp[5:0]];
  always @(posedge clk) if (fifo_pop) rp <= rp + 1;

  always @(negedge clk) begin
    tcnt = (tcnt + 1) % tdiv;
    tick_1m = (tcnt == 0) && !thold;
    if (txnull_mon && (tx_hi || tx_lo)) txnull_err++;
  end

  a429_tx_serializer dut (
    .clk(clk), .rst(rst), .tick_1m(tick_1m),
    .cfg_low_speed(cfg_low_speed), .cfg_par_en(cfg_par_en),
    .cfg_par_even(cfg_par_even), .cfg_auto_start(cfg_auto_start),
    .cfg_drv_off(cfg_drv_off), .start_pulse(start_pulse),
    .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_pop(fifo_pop),
    .tx_hi(tx_hi), .tx_lo(tx_lo), .loop_hi(loop_hi), .loop_lo(loop_lo),
    .drained(drained)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] w);
    fm[wp[5:0]] = w;
    wp++;
  endtask

  function automatic logic [31:0] expw(input logic [31:0] w, input bit pen, input bit pev);
    logic p;
    p = ^w[30:0];
    if (!pen) return w;
    return {(pev ? p : ~p), w[30:0]};
  endfunction

  function automatic logic s_hi(input bit lp);
    return lp ? loop_hi : tx_hi;
  endfunction
  function automatic logic s_lo(input bit lp);
    return lp ? loop_lo : tx_lo;
  endfunction

  // Decode one word from the lines; called and returns at a negedge.
  task automatic rx_word(input int half, input bit lp, output logic [31:0] w,
                         output int gapn, output int wbad);
    logic v;
    int n;
    w = '0; wbad = 0; gapn = 0;
    while (!s_hi(lp) && !s_lo(lp) && gapn < 20000) begin
      gapn++; @(negedge clk);
    end
    if (gapn >= 20000) begin wbad = 1000; return; end
    for (int b = 0; b < 32; b++) begin
      v = s_hi(lp);
      n = 0;
      while (s_hi(lp) == v && s_lo(lp) == !v && n < 20000) begin
        n++; @(negedge clk);
      end
      if (half > 0 && n != half) wbad++;
      w[b] = v;
      if (b < 31) begin
        n = 0;
        while (!s_hi(lp) && !s_lo(lp) && n < 20000) begin
          n++; @(negedge clk);
        end
        if (half > 0 && n != half) wbad++;
      end
    end
  endtask

  task automatic wait_drained();
    int n = 0;
    while (!drained && n < 20000) begin n++; @(negedge clk); end
    repeat (3) @(negedge clk);
  endtask

  logic [31:0] got;
  int gapn, wbad;

  initial begin : main
    logic [31:0] words [0:7];
    words[0] = 32'h0000_0001; words[1] = 32'h8000_0000;
    words[2] = 32'hAAAA_AAAA; words[3] = 32'h5555_5555;
    words[4] = 32'hFFFF_FFFF; words[5] = 32'h0000_0000;
    words[6] = 32'h1234_5678; words[7] = 32'hC3A5_0F96;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk(!tx_hi && !tx_lo && !loop_hi && !loop_lo && !fifo_pop, "R1 reset lines",
        {tx_hi, tx_lo, loop_hi, loop_lo, fifo_pop}, 0);
    rst = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(drained == 1'b1, "R1 drained after reset", drained, 1);

    // R8 launch latency
    push(32'h0000_0003);
    @(negedge clk);
    chk(rp == wp && !tx_hi && !tx_lo, "R8 pop next edge", rp, wp);
    @(negedge clk);
    chk(tx_hi == 1'b1 && tx_lo == 1'b0, "R8 first data one clock after pop", {tx_hi, tx_lo}, 2'b10);
    rx_word(0, 0, got, gapn, wbad);
    chk(got == 32'h3, "R8 R2 latency word value", got, 32'h3);
    wait_drained();

    // R2 R3 R5 R6 high speed back to back, parity off
    for (int i = 0; i < 8; i++) push(words[i]);
    for (int i = 0; i < 8; i++) begin
      rx_word(5, 0, got, gapn, wbad);
      chk(got == words[i], "R2 R6 word value", got, words[i]);
      chk(wbad == 0, "R3 half widths", wbad, 0);
      if (i > 0) chk(gapn == 45, "R5 high speed gap", gapn, 45);
      if (i == 7) chk(drained == 1'b0, "R11 low during gap", drained, 0);
    end
    wait_drained();
    chk(drained == 1'b1, "R11 high after last word", drained, 1);

    // R7 parity odd over walking ones, then even
    cfg_par_en = 1'b1;
    for (int i = 0; i < 32; i++) push(32'h1 << i);
    for (int i = 0; i < 32; i++) begin
      rx_word(5, 0, got, gapn, wbad);
      chk(got == expw(32'h1 << i, 1, 0), "R7 odd parity", got, expw(32'h1 << i, 1, 0));
    end
    wait_drained();
    cfg_par_even = 1'b1;
    for (int i = 0; i < 8; i++) push(words[i] ^ (32'h3 << (2 * i)));
    for (int i = 0; i < 8; i++) begin
      rx_word(5, 0, got, gapn, wbad);
      chk(got == expw(words[i] ^ (32'h3 << (2 * i)), 1, 1), "R7 even parity", got,
          expw(words[i] ^ (32'h3 << (2 * i)), 1, 1));
    end
    wait_drained();
    cfg_par_en = 1'b0; cfg_par_even = 1'b0;

    // R4 R5 low speed
    cfg_low_speed = 1'b1;
    push(32'hF0F0_1234); push(32'h0F0F_8765);
    rx_word(40, 0, got, gapn, wbad);
    chk(got == 32'hF0F0_1234 && wbad == 0, "R4 low speed word", got, 32'hF0F0_1234);
    rx_word(40, 0, got, gapn, wbad);
    chk(got == 32'h0F0F_8765 && wbad == 0, "R4 low speed second word", got, 32'h0F0F_8765);
    chk(gapn == 360, "R5 low speed gap", gapn, 360);
    wait_drained();
    cfg_low_speed = 1'b0;

    // R9 R10 strobe mode
    cfg_auto_start = 1'b0;
    @(negedge clk);
    push(32'h1111_0001); push(32'h2222_0002);
    begin
      int e = 0;
      for (int k = 0; k < 300; k++) begin
        @(negedge clk);
        if (tx_hi || tx_lo || rp != wp - 2) e++;
      end
      chk(e == 0, "R9 no send before strobe", e, 0);
    end
    start_pulse = 1'b1; @(negedge clk); start_pulse = 1'b0;
    rx_word(5, 0, got, gapn, wbad);
    chk(got == 32'h1111_0001, "R10 first strobed word", got, 32'h1111_0001);
    push(32'h3333_0003);
    rx_word(5, 0, got, gapn, wbad);
    chk(got == 32'h2222_0002, "R10 second strobed word", got, 32'h2222_0002);
    rx_word(5, 0, got, gapn, wbad);
    chk(got == 32'h3333_0003, "R10 word added during drain", got, 32'h3333_0003);
    wait_drained();
    push(32'h4444_0004);
    begin
      int e = 0;
      for (int k = 0; k < 500; k++) begin
        @(negedge clk);
        if (tx_hi || tx_lo || rp == wp) e++;
      end
      chk(e == 0, "R10 late word waits", e, 0);
    end
    start_pulse = 1'b1; @(negedge clk); start_pulse = 1'b0;
    rx_word(5, 0, got, gapn, wbad);
    chk(got == 32'h4444_0004, "R10 second strobe", got, 32'h4444_0004);
    wait_drained();
    cfg_auto_start = 1'b1;

    // R12 driver disable, loopback still active
    cfg_drv_off = 1'b1;
    @(negedge clk);
    txnull_mon = 1'b1;
    push(32'hDEAD_BEEF);
    rx_word(5, 1, got, gapn, wbad);
    chk(got == 32'hDEAD_BEEF && wbad == 0, "R12 loopback word", got, 32'hDEAD_BEEF);
    wait_drained();
    txnull_mon = 1'b0;
    chk(txnull_err == 0, "R12 lines null", txnull_err, 0);
    cfg_drv_off = 1'b0;

    // R14 enable held low, then divided enable
    thold = 1'b1;
    push(32'h0000_00FF);
    repeat (3) @(negedge clk);
    begin
      int e = 0;
      for (int k = 0; k < 100; k++) begin
        if (!(tx_hi && !tx_lo)) e++;
        @(negedge clk);
      end
      chk(e == 0, "R14 hold without tick", e, 0);
    end
    thold = 1'b0;
    rx_word(0, 0, got, gapn, wbad);
    chk(got == 32'h0000_00FF, "R14 word after hold", got, 32'hFF);
    wait_drained();
    tdiv = 3;
    push(32'h9ABC_DEF0);
    rx_word(0, 0, got, gapn, wbad);
    chk(got == 32'h9ABC_DEF0, "R14 divided tick word", got, 32'h9ABC_DEF0);
    wait_drained();
    tdiv = 1;

    // R13 reset mid-word
    push(32'hFFFF_FFFF);
    while (!tx_hi) @(negedge clk);
    repeat (30) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(!tx_hi && !tx_lo, "R13 null after reset edge", {tx_hi, tx_lo}, 0);
    @(negedge clk);
    rst = 1'b0;
    begin
      int e = 0;
      for (int k = 0; k < 400; k++) begin
        @(negedge clk);
        if (tx_hi || tx_lo) e++;
      end
      chk(e == 0, "R13 aborted word not resumed", e, 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule